// File: doc/BRIEF.md
# Multi-Requester Zero-Wait Node Store

This block is a shared store for tree nodes produced by several exploration engines running side by side. Every engine owns one write lane made of a valid bit and a node word. Each clock cycle is one write window. The valid bits form a request vector with one bit per engine. A decoder turns that vector straight into per-bank write enables. Any subset of engines, from none to all, commits in the same window, and no engine ever waits for another.

Storage is split into independent banks, one per engine. Each bank has its own append pointer, and together the banks form one flat address space. The upper address bits pick the bank and the lower bits pick the slot inside it. Because each engine writes only its own bank, two writes can never meet in the same bank. Every accepted write is answered one cycle later by a single-cycle acknowledge that carries the global address where the node landed. A separate read port takes a global address, routes it through the same bank/offset split, and returns the stored node one cycle later. It works alongside the writes without blocking them.

A node holds two coordinates. Each is a 32-bit two's-complement fixed-point number with 24 integer bits and 8 fraction bits.

Top module: `node_store`

## Requirements
- R1: After reset, every ready bit is high and every acknowledge bit and the read-valid bit are low. The first accepted write of each requester lands at local offset 0.
- R2: In one window, every requester whose valid and ready bits are both high is acknowledged in the next cycle. This holds for any combination of requesters, all at once, with no stall.
- R3: An acknowledge lasts exactly one cycle per accepted write. A requester with valid low in a window gets no acknowledge in the next cycle.
- R4: The acknowledge address is a global address. Bits [ADDR_W-1:OFF_W] carry the requester index and bits [OFF_W-1:0] carry the local offset. One requester's accepted writes take offsets 0, 1, 2, … in order.
- R5: Raising rd_en_i with a global address gives rd_valid_o high in the next cycle. In that cycle rd_node_o is the node in bank addr[ADDR_W-1:OFF_W] at offset addr[OFF_W-1:0]. rd_valid_o is low in the cycle after rd_en_i is low.
- R6: A read and any set of writes in the same window all complete in that window. The read returns the contents stored before that window.
- R7: After BANK_DEPTH accepted writes, a requester's ready bit is low and stays low until reset. A valid write from it then gets no acknowledge and changes no stored node. Other requesters keep working.
- R8: A node word is {x, y}, with x in bits [63:32] and y in bits [31:0]. Each coordinate is 32-bit two's-complement 24.8 fixed point. Words, negative values included, come back bit-exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one write window per cycle |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_valid_i | input | N_REQ | Request vector, one bit per requester |
| wr_node_i | input | N_REQ*64 | Node word per requester, lane i at [i*64 +: 64] |
| wr_ready_o | output | N_REQ | Requester's bank still has room |
| wr_ack_o | output | N_REQ | One-cycle pulse per committed write |
| wr_ack_addr_o | output | N_REQ*ADDR_W | Global address of the committed node, lane i at [i*ADDR_W +: ADDR_W] |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Global read address |
| rd_valid_o | output | 1 | Read data valid |
| rd_node_o | output | 64 | Node word read |

## Verification
The bench walks a table of request vectors that covers no requesters, each single requester, pairs, triples and all four. A decoder that dropped or serialised any combination would show a missing acknowledge or a skipped offset. Some windows also read nodes from earlier windows, so read data from the wrong bank, or a read stalled by writes, shows as a mismatch. One bank is filled to capacity and then pushed once more. A design that wrapped its pointer or kept writing would acknowledge that write or overwrite the last node. A reset in mid-run must bring every pointer back to offset 0.

// File: rtl/node_store_pkg.sv
package node_store_pkg;

    // One coordinate: two's-complement fixed point, 24 integer and 8 fraction bits.
    localparam int COORD_W = 32;

    typedef struct packed {
        logic signed [COORD_W-1:0] x;
        logic signed [COORD_W-1:0] y;
    } node_t;

    localparam int NODE_W = $bits(node_t);

endpackage

// File: rtl/node_store_decode.sv
// Request-vector decoder: turns the requester bit vector and the bank
// fill state into per-bank write enables, and the read bank field into a
// one-hot bank select. Purely combinational, so every subset of requests
// resolves inside the window.
module node_store_decode #(
    parameter int N_REQ = 4,
    parameter int SEL_W = 2
) (
    input  logic [N_REQ-1:0] req_i,
    input  logic [N_REQ-1:0] full_i,
    input  logic             rd_en_i,
    input  logic [SEL_W-1:0] rd_sel_i,
    output logic [N_REQ-1:0] bank_we_o,
    output logic [N_REQ-1:0] rd_bank_oh_o
);

    for (genvar b = 0; b < N_REQ; b++) begin : g_bank
        assign bank_we_o[b]    = req_i[b] & ~full_i[b];
        assign rd_bank_oh_o[b] = rd_en_i && (rd_sel_i == SEL_W'(b));
    end

endmodule

// File: rtl/node_store_bank.sv
// One single-channel bank with a private append pointer.
module node_store_bank #(
    parameter int DEPTH  = 16,
    parameter int OFF_W  = 4,
    parameter int NODE_W = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [NODE_W-1:0] wdata_i,
    input  logic [OFF_W-1:0]  rd_off_i,
    output logic [NODE_W-1:0] rdata_o,
    output logic [OFF_W-1:0]  wr_off_o,
    output logic              full_o
);

    localparam int PTR_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [NODE_W-1:0] mem [DEPTH];
    logic              commit;

    assign full_o   = (st_q.ptr == PTR_W'(DEPTH));
    assign commit   = we_i && !full_o;
    assign wr_off_o = st_q.ptr[OFF_W-1:0];
    assign rdata_o  = mem[rd_off_i];

    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Storage array: no reset, written only on a committed append.
    always_ff @(posedge clk_i) begin
        if (commit) begin
            mem[st_q.ptr[OFF_W-1:0]] <= wdata_i;
        end
    end

endmodule

// File: rtl/node_store_rdmux.sv
// Read-path multiplexer: picks one bank's word with a one-hot select.
module node_store_rdmux #(
    parameter int N_REQ  = 4,
    parameter int NODE_W = 64
) (
    input  logic [N_REQ*NODE_W-1:0] bank_data_i,
    input  logic [N_REQ-1:0]        sel_oh_i,
    output logic [NODE_W-1:0]       data_o
);

    always_comb begin
        data_o = '0;
        for (int b = 0; b < N_REQ; b++) begin
            if (sel_oh_i[b]) begin
                data_o = data_o | bank_data_i[b*NODE_W +: NODE_W];
            end
        end
    end

endmodule

// File: rtl/node_store.sv
module node_store
    import node_store_pkg::*;
#(
    parameter int N_REQ      = 4,
    parameter int BANK_DEPTH = 16,   // power of two
    localparam int OFF_W  = $clog2(BANK_DEPTH),
    localparam int SEL_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1,
    localparam int ADDR_W = SEL_W + OFF_W
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [N_REQ-1:0]        wr_valid_i,
    input  logic [N_REQ*NODE_W-1:0] wr_node_i,
    output logic [N_REQ-1:0]        wr_ready_o,
    output logic [N_REQ-1:0]        wr_ack_o,
    output logic [N_REQ*ADDR_W-1:0] wr_ack_addr_o,
    input  logic                    rd_en_i,
    input  logic [ADDR_W-1:0]       rd_addr_i,
    output logic                    rd_valid_o,
    output logic [NODE_W-1:0]       rd_node_o
);

    typedef struct packed {
        logic [N_REQ-1:0]        ack;
        logic [N_REQ*ADDR_W-1:0] ack_addr;
        logic                    rd_valid;
        logic [NODE_W-1:0]       rd_node;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [N_REQ-1:0]        full;
    logic [N_REQ-1:0]        bank_we;
    logic [N_REQ-1:0]        rd_oh;
    logic [N_REQ*OFF_W-1:0]  wr_off;
    logic [N_REQ*NODE_W-1:0] bank_rdata;
    logic [NODE_W-1:0]       rd_word;

    node_store_decode #(
        .N_REQ (N_REQ),
        .SEL_W (SEL_W)
    ) u_decode (
        .req_i        (wr_valid_i),
        .full_i       (full),
        .rd_en_i      (rd_en_i),
        .rd_sel_i     (rd_addr_i[ADDR_W-1:OFF_W]),
        .bank_we_o    (bank_we),
        .rd_bank_oh_o (rd_oh)
    );

    for (genvar b = 0; b < N_REQ; b++) begin : g_bank
        node_store_bank #(
            .DEPTH  (BANK_DEPTH),
            .OFF_W  (OFF_W),
            .NODE_W (NODE_W)
        ) u_bank (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .we_i     (bank_we[b]),
            .wdata_i  (wr_node_i[b*NODE_W +: NODE_W]),
            .rd_off_i (rd_addr_i[OFF_W-1:0]),
            .rdata_o  (bank_rdata[b*NODE_W +: NODE_W]),
            .wr_off_o (wr_off[b*OFF_W +: OFF_W]),
            .full_o   (full[b])
        );
    end

    node_store_rdmux #(
        .N_REQ  (N_REQ),
        .NODE_W (NODE_W)
    ) u_rdmux (
        .bank_data_i (bank_rdata),
        .sel_oh_i    (rd_oh),
        .data_o      (rd_word)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ack      = bank_we & ~full;
        st_d.rd_valid = rd_en_i;
        if (rd_en_i) begin
            st_d.rd_node = rd_word;
        end
        for (int i = 0; i < N_REQ; i++) begin
            if (bank_we[i] && !full[i]) begin
                st_d.ack_addr[i*ADDR_W +: ADDR_W] = {SEL_W'(i), wr_off[i*OFF_W +: OFF_W]};
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ready_o    = ~full;
    assign wr_ack_o      = st_q.ack;
    assign wr_ack_addr_o = st_q.ack_addr;
    assign rd_valid_o    = st_q.rd_valid;
    assign rd_node_o     = st_q.rd_node;

endmodule

// File: rtl/node_store_chk.sv
module node_store_chk #(
    parameter int N_REQ      = 4,
    parameter int BANK_DEPTH = 16,
    localparam int OFF_W  = $clog2(BANK_DEPTH),
    localparam int SEL_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1,
    localparam int ADDR_W = SEL_W + OFF_W
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic [N_REQ-1:0]        wr_valid_i,
    input logic [N_REQ-1:0]        wr_ready_o,
    input logic [N_REQ-1:0]        wr_ack_o,
    input logic [N_REQ*ADDR_W-1:0] wr_ack_addr_o,
    input logic                    rd_en_i,
    input logic                    rd_valid_o
);

    // R2
    ack_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_valid_i & wr_ready_o) != '0 |=> wr_ack_o == $past(wr_valid_i & wr_ready_o));

    // R3
    ack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_valid_i & wr_ready_o) == '0 |=> wr_ack_o == '0);

    // R7
    full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_valid_i & ~wr_ready_o) != '0 |=> (wr_ack_o & $past(wr_valid_i & ~wr_ready_o)) == '0);

    // R7
    full_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (~wr_ready_o) != '0 |=> ((~$past(wr_ready_o)) & wr_ready_o) == '0);

    // R5
    rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i |=> rd_valid_o);

    // R5
    rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> !rd_valid_o);

    for (genvar i = 0; i < N_REQ; i++) begin : g_req
        // R4
        offset_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            wr_ack_o[i] && $past(wr_ack_o[i]) |->
            wr_ack_addr_o[i*ADDR_W +: OFF_W] == OFF_W'($past(wr_ack_addr_o[i*ADDR_W +: OFF_W]) + 1'b1));
    end

endmodule

bind node_store node_store_chk #(
    .N_REQ      (N_REQ),
    .BANK_DEPTH (BANK_DEPTH)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_valid_i    (wr_valid_i),
    .wr_ready_o    (wr_ready_o),
    .wr_ack_o      (wr_ack_o),
    .wr_ack_addr_o (wr_ack_addr_o),
    .rd_en_i       (rd_en_i),
    .rd_valid_o    (rd_valid_o)
);

// File: tb/sim_node_store.sv
`timescale 1ns/1ps
module sim_node_store;
    import node_store_pkg::*;

    localparam int NR  = 4;
    localparam int DEP = 16;
    localparam int OW  = 4;
    localparam int SW  = 2;
    localparam int AW  = 6;
    localparam int NW  = 64;

    // Table entry: {request mask[10:7], read enable[6], read address[5:0]}
    localparam logic [10:0] TBL [16] = '{
        {4'b0000, 1'b0, 6'd0},
        {4'b0001, 1'b0, 6'd0},
        {4'b0010, 1'b0, 6'd0},
        {4'b0100, 1'b0, 6'd0},
        {4'b1000, 1'b0, 6'd0},
        {4'b0011, 1'b0, 6'd0},
        {4'b1100, 1'b0, 6'd0},
        {4'b0101, 1'b0, 6'd0},
        {4'b1010, 1'b0, 6'd0},
        {4'b1111, 1'b0, 6'd0},
        {4'b0000, 1'b0, 6'd0},
        {4'b0111, 1'b1, 6'd0},
        {4'b1110, 1'b1, 6'd16},
        {4'b1111, 1'b1, 6'd33},
        {4'b0000, 1'b1, 6'd48},
        {4'b1001, 1'b1, 6'd5}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NR-1:0]     wr_valid = '0;
    logic [NR*NW-1:0]  wr_node = '0;
    logic [NR-1:0]     wr_ready;
    logic [NR-1:0]     wr_ack;
    logic [NR*AW-1:0]  wr_ack_addr;
    logic              rd_en = 1'b0;
    logic [AW-1:0]     rd_addr = '0;
    logic              rd_valid;
    logic [NW-1:0]     rd_node;

    int    errors = 0;
    int    checks = 0;
    int    step_no = 0;
    int    cnt [NR];
    node_t exp_mem [NR][DEP];

    always #2.5 clk = ~clk;

    node_store #(.N_REQ(NR), .BANK_DEPTH(DEP)) u0 (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .wr_valid_i    (wr_valid),
        .wr_node_i     (wr_node),
        .wr_ready_o    (wr_ready),
        .wr_ack_o      (wr_ack),
        .wr_ack_addr_o (wr_ack_addr),
        .rd_en_i       (rd_en),
        .rd_addr_i     (rd_addr),
        .rd_valid_o    (rd_valid),
        .rd_node_o     (rd_node)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic node_t mk_node(input int tag, input int i);
        node_t n;
        n.x = 32'((tag * 37 + i * 11 - 200) * 256 + i * 5);
        n.y = 32'(-(tag * 13 + i) * 256 - 128 + i);
        return n;
    endfunction

    // One window: drive at negedge, check ready, then check ack/read after the edge.
    task automatic cycle(input logic [NR-1:0] mask, input logic ren, input logic [AW-1:0] raddr);
        logic [NR-1:0] exp_ready;
        logic [NR-1:0] exp_ack;
        node_t         exp_rd;
        @(negedge clk);
        step_no++;
        for (int i = 0; i < NR; i++) begin
            wr_node[i*NW +: NW] = mk_node(step_no, i);
            exp_ready[i] = (cnt[i] < DEP);
        end
        wr_valid = mask;
        rd_en    = ren;
        rd_addr  = raddr;
        exp_ack  = mask & exp_ready;
        exp_rd   = exp_mem[raddr[AW-1:OW]][raddr[OW-1:0]];
        #0.5;
        chk(wr_ready == exp_ready, "R7 ready", 64'(wr_ready), 64'(exp_ready));
        @(posedge clk);
        #1;
        chk(wr_ack == exp_ack, "R2 ack vector", 64'(wr_ack), 64'(exp_ack));
        for (int i = 0; i < NR; i++) begin
            if (exp_ack[i]) begin
                logic [AW-1:0] ea;
                ea = {SW'(i), OW'(cnt[i])};
                chk(wr_ack_addr[i*AW +: AW] == ea, "R4 ack address",
                    64'(wr_ack_addr[i*AW +: AW]), 64'(ea));
                exp_mem[i][cnt[i]] = mk_node(step_no, i);
                cnt[i]++;
            end
        end
        chk(rd_valid == ren, "R5 rd_valid", 64'(rd_valid), 64'(ren));
        if (ren) begin
            chk(rd_node == exp_rd, "R6 read data beside writes", rd_node, exp_rd);
        end
    endtask

    initial begin
        for (int i = 0; i < NR; i++) cnt[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(wr_ready == 4'b1111, "R1 ready after reset", 64'(wr_ready), 64'hf);
        chk(wr_ack == 4'b0000, "R1 ack after reset", 64'(wr_ack), 64'h0);
        chk(rd_valid == 1'b0, "R1 rd_valid after reset", 64'(rd_valid), 64'h0);

        // R2 R3 R4 R6: walk the request table
        for (int k = 0; k < 16; k++) begin
            cycle(TBL[k][10:7], TBL[k][6], TBL[k][5:0]);
        end

        // R5 R8: read back every stored node (negative coordinates included)
        for (int b = 0; b < NR; b++) begin
            for (int o = 0; o < cnt[b]; o++) begin
                cycle(4'b0000, 1'b1, {SW'(b), OW'(o)});
                chk(rd_node == exp_mem[b][o], "R8 node word bit-exact", rd_node, exp_mem[b][o]);
            end
        end
        cycle(4'b0000, 1'b0, '0);   // R5 rd_valid falls, R3 no ack

        // R7: fill requester 3, then push once more beside requester 0
        while (cnt[3] < DEP) cycle(4'b1000, 1'b0, '0);
        cycle(4'b1001, 1'b0, '0);
        chk(wr_ack[3] == 1'b0, "R7 dropped write not acked", 64'(wr_ack[3]), 64'h0);
        chk(wr_ack[0] == 1'b1, "R7 other requester still acked", 64'(wr_ack[0]), 64'h1);
        cycle(4'b0000, 1'b1, {2'd3, 4'd15});
        chk(rd_node == exp_mem[3][DEP-1], "R7 last node unchanged", rd_node, exp_mem[3][DEP-1]);
        chk(wr_ready[3] == 1'b0, "R7 ready stays low", 64'(wr_ready[3]), 64'h0);

        // R1: reset in mid-run restarts every pointer
        @(negedge clk);
        rst_n = 1'b0;
        wr_valid = '0;
        rd_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NR; i++) cnt[i] = 0;
        #1;
        chk(wr_ready == 4'b1111, "R1 ready after second reset", 64'(wr_ready), 64'hf);
        chk(wr_ack == 4'b0000, "R1 ack after second reset", 64'(wr_ack), 64'h0);
        cycle(4'b1000, 1'b0, '0);
        cycle(4'b0000, 1'b1, {2'd3, 4'd0});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule